// File: doc/BRIEF.md
# Maskable interrupt aggregator

This block gathers a small set of interrupt events into one sticky status register and drives a single combined interrupt line towards the processor. Seven of the sources arrive as single-cycle (or held) event inputs. The eighth source, bit 0, is derived inside the block from the rising edge of the level-sensitive core interrupt line.

Software reaches the block through a plain register port that has three addresses:
- A mask register, where a 1 enables a source.
- The status register. A write of 1 forces a bit on. A read returns the latched bits, with the live core interrupt level in the top bit.
- A separate clear address. A write of 1 removes a bit.

The combined output is high whenever an enabled bit is latched.

Source positions are: 0 core-line rising edge, 1 hot-plug rise, 2 hot-plug fall, 3 nonce refresh, 4 random-number error, 5 I2C timeout, 6 receiver-sense rise, 7 receiver-sense fall.

Top module: `irq_aggregator`

## Requirements
- R1: After the active-low asynchronous reset, the mask reads 0, the status bits 7:0 read 0 and `irq_out` is 0.
- R2: A write to address 0 loads the mask from data bits 7:0. A read of address 0 returns the mask in bits 7:0 and zeros above.
- R3: Status bit 0 is set at a clock edge where `core_irq` is 1 and it was 0 at the previous edge. A line held high does not set the bit again once it has been cleared.
- R4: A clock edge with `evt_in[k]` at 1 sets status bit k, for k from 1 to 7.
- R5: A write to address 1 sets every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R6: A read of address 1 returns status in bits 7:0, zeros in bits 30:8, and the present `core_irq` level in bit 31.
- R7: A write to address 2 clears every status bit whose data bit is 1 and leaves the others. A read of address 2, or of address 3, returns 0.
- R8: When a hardware event and a clear of the same bit fall on the same edge, the bit ends set.
- R9: `irq_out` is the OR over bits 7:0 of status AND mask. It follows the registers with no extra cycle.
- R10: A set status bit stays set after its event is removed, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_irq | input | 1 | Level of the core's own interrupt line |
| evt_in | input | 7 | Event inputs for status bits 7:1 (`evt_in[k]` sets bit k) |
| reg_wr | input | 1 | Write strobe, taken at the clock edge |
| reg_addr | input | 2 | Register address: 0 mask, 1 status, 2 clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The hardest situation to reach is a hardware event and a software clear landing on the same bit at the same edge. The bench reaches it by holding an event input high during the cycle of a clear write, and it checks that the event bit survives while the other cleared bits drop.

The held core line is the second difficult case. The bench clears bit 0 while `core_irq` stays high, confirms the bit does not come back, and then drops and raises the line to produce a new edge.

The output logic is swept over all 256 mask values against several forced status patterns.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MASK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Next value of one sticky status bit: any set wins over a clear.
  function automatic logic status_next(input logic cur, input logic hw,
                                       input logic sws, input logic clr);
    return hw | sws | (cur & ~clr);
  endfunction
endpackage

// File: rtl/irq_rise_detect.sv
module irq_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R3: an edge pulse needs the line high and never lasts two cycles
  a_r3_level_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> lvl);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/irq_status_cell.sv
module irq_status_cell
  import irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_set,
  input  logic sw_clr,
  output logic bit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= status_next(bit_q, hw_set, sw_set, sw_clr);
  end

  a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> bit_q);
  a_r5_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set |=> bit_q);
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !hw_set && !sw_set) |=> !bit_q);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q && !sw_clr) |=> bit_q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 core_irq,
  input  logic [NUM_SRC-1:1]   evt_in,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_out
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC - 1;

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] hw_set;
  logic [NUM_SRC-1:0] sw_set;
  logic [NUM_SRC-1:0] sw_clr;
  logic               core_rise;
  logic               wr_mask, wr_stat, wr_clr;

  irq_rise_detect u_core_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (core_irq),
    .rise (core_rise)
  );

  assign hw_set  = {evt_in, core_rise};
  assign wr_mask = reg_wr && (reg_addr == SEL_MASK);
  assign wr_stat = reg_wr && (reg_addr == SEL_STAT);
  assign wr_clr  = reg_wr && (reg_addr == SEL_CLR);
  assign sw_set  = wr_stat ? reg_wdata[NUM_SRC-1:0] : '0;
  assign sw_clr  = wr_clr  ? reg_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[NUM_SRC-1:0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    irq_status_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .hw_set(hw_set[i]),
      .sw_set(sw_set[i]),
      .sw_clr(sw_clr[i]),
      .bit_q (stat_q[i])
    );
  end

  always_comb begin
    unique case (reg_addr)
      SEL_MASK: reg_rdata = {{(DATA_W-NUM_SRC){1'b0}}, mask_q};
      SEL_STAT: reg_rdata = {core_irq, {PAD_W{1'b0}}, stat_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_out = |(stat_q & mask_q);

  a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask_q == $past(reg_wdata[NUM_SRC-1:0]));
  a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(mask_q) != mask_q) || ($past(stat_q) != stat_q));
  a_r3_core_latch: assert property (@(posedge clk) disable iff (!rst_n)
    core_rise |=> stat_q[0]);
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        core_irq;
  logic [7:1]  evt_in;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .core_irq(core_irq), .evt_in(evt_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; core_irq = 1'b0; evt_in = '0;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 mask", d, 32'h0);
    rd(2'd1, d); check("R1 status", d, 32'h0);
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);

    // R2 mask write/read, upper bits dropped
    wr(2'd0, 32'hFFFF_FF5A);
    rd(2'd0, d); check("R2 mask readback", d, 32'h5A);

    // R5 software set, zeros leave bits
    wr(2'd1, 32'h0000_0011);
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, d); check("R5 soft set", d, 32'h11);
    wr(2'd1, 32'h0000_0082);
    rd(2'd1, d); check("R5 soft set merge", d, 32'h93);

    // R7 clear, zero bits kept; clear address reads 0
    wr(2'd2, 32'h0000_0011);
    rd(2'd1, d); check("R7 clear", d, 32'h82);
    rd(2'd2, d); check("R7 clear addr reads 0", d, 32'h0);
    rd(2'd3, d); check("R7 addr3 reads 0", d, 32'h0);
    wr(2'd2, 32'hFF);

    // R4 and R10 each event input, then sticky after removal
    for (int k = 1; k < 8; k++) begin
      evt_in = 7'(1 << (k-1));
      tick();
      evt_in = '0;
      tick();
      rd(2'd1, d); check("R4/R10 event sticky", d, 32'(1 << k));
      wr(2'd2, 32'hFF);
    end

    // R6 live core level in bit 31, R3 edge latch
    core_irq = 1'b1;
    rd(2'd1, d); check("R6 bit31 live", d[31], 1'b1);
    tick();
    rd(2'd1, d); check("R3 rise latches", d, 32'h8000_0001);
    wr(2'd2, 32'h1);
    tick();
    rd(2'd1, d); check("R3 held high no relatch", d, 32'h8000_0000);
    core_irq = 1'b0;
    tick();
    rd(2'd1, d); check("R6 bit31 low", d, 32'h0);
    core_irq = 1'b1;
    tick();
    core_irq = 1'b0;
    rd(2'd1, d); check("R3 new edge", d, 32'h1);
    wr(2'd2, 32'hFF);

    // R8 event vs clear on same edge
    wr(2'd1, 32'h0000_00F0);
    evt_in = 7'b0000100; // bit 3
    wr(2'd2, 32'hFF);
    evt_in = '0;
    rd(2'd1, d); check("R8 event wins", d, 32'h08);
    wr(2'd2, 32'hFF);

    // R9 sweep over all masks against patterns
    for (int m = 0; m < 256; m++) begin
      wr(2'd0, 32'(m));
      for (int p = 0; p < 3; p++) begin
        logic [7:0] s;
        s = (p == 0) ? 8'(1 << (m % 8)) : (p == 1) ? ~8'(m) : 8'(m);
        wr(2'd2, 32'hFF);
        wr(2'd1, {24'b0, s});
        check("R9 irq_out", {31'b0, irq_out}, {31'b0, ((s & 8'(m)) != 8'h0)});
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule